// File: doc/BRIEF.md
# I/O-Port Watchdog Reset Timer

This block is a system watchdog that a host drives only through accesses on a small I/O bus. The bus has an address, a read strobe, a write strobe and a byte of write data. No read data is returned, because control works entirely through the side effects of each access. Writing a byte to the timer port stores a timeout period, counted in whole seconds from 1 to 255. Reading that same port arms the timer, or restarts it if it is already armed. Reading either of two halt ports disarms it.

While armed, the block counts the stored period down once per second. The one-second tick comes from a prescaler of `CLKS_PER_SEC` system clocks, and the prescaler starts again from zero on every arm or restart. If software does not restart the timer before the count runs out, the block drives a reset pulse `RST_PULSE_CLKS` clocks long. It then returns to the disarmed state and keeps the stored period. A status output shows whether the timer is armed, and a debug output gives the seconds that remain.

Top module: `wdt_ioport`

## Requirements
- R1: While `rst_n` is low, and after it is released, `armed` is 0, `reset_out` is 0 and `secs_left` is 0. The stored period is cleared to 0, so an arm read that follows any reset has no effect.
- R2: A write strobe at address 0x0543 stores `io_wdata` as the period. The write does not arm the timer.
- R3: A read strobe at address 0x0543, while the stored period is nonzero and no reset pulse is active, arms the timer. From the next cycle `armed` is 1 and `secs_left` equals the stored period.
- R4: A read strobe at 0x0543 while the stored period is 0 is ignored. A disarmed timer stays disarmed, and an armed timer keeps its count.
- R5: A read strobe at address 0x0143 or at address 0x0943 disarms the timer. From the next cycle `armed` is 0 and `secs_left` is 0.
- R6: While armed, `secs_left` drops by exactly 1 every `CLKS_PER_SEC` clocks. The first drop comes `CLKS_PER_SEC` clocks after the most recent arm or refresh read.
- R7: An arm read while the timer is armed reloads `secs_left` from the stored period. Writing a new period while armed leaves the running count unchanged.
- R8: With stored period P and no later refresh, `reset_out` rises P×`CLKS_PER_SEC` clocks after the arming read. It stays high for exactly `RST_PULSE_CLKS` clocks with `armed` at 0. The timer then stays disarmed, and the period P is kept.
- R9: Accesses to any other address, and writes to 0x0143, change neither the arm state nor the count.
- R10: Reads and writes made while `reset_out` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| io_addr | input | ADDR_W | I/O bus address |
| io_rd | input | 1 | I/O read strobe, one access per cycle it is high |
| io_wr | input | 1 | I/O write strobe, one access per cycle it is high |
| io_wdata | input | 8 | I/O write data |
| reset_out | output | 1 | Active-high system reset pulse on expiry |
| armed | output | 1 | Timer is armed and counting |
| secs_left | output | 8 | Seconds remaining while armed, otherwise 0 |

## Verification
The properties assume that each strobe marks one complete access per cycle and that `io_rd` and `io_wr` are never high together. Under that assumption, an access of one kind on a port cannot hide the effect of an access of the other kind. The bench holds every strobe for exactly one clock, changes bus signals only on the falling edge, and returns both strobes to 0 between accesses. It uses a short prescaler and a short pulse, so every timing window is exercised, including expiry and refresh just before expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_mode_e;

    // one-cycle bus requests produced by the port decoder
    typedef struct packed {
        logic load;   // period write
        logic kick;   // arm / refresh read
        logic halt;   // disarm read
    } wd_req_t;

endpackage

// File: rtl/wdt_port_decode.sv
module wdt_port_decode #(
    parameter int unsigned          ADDR_W      = 16,
    parameter logic [ADDR_W-1:0]    TIMER_PORT  = 'h0543,
    parameter logic [ADDR_W-1:0]    HALT_PORT_A = 'h0143,
    parameter logic [ADDR_W-1:0]    HALT_PORT_B = 'h0943
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output wdt_pkg::wd_req_t  req
);
    logic hit_timer;
    logic hit_halt;

    always_comb begin
        hit_timer = (io_addr == TIMER_PORT);
        hit_halt  = (io_addr == HALT_PORT_A) || (io_addr == HALT_PORT_B);
        req.load  = io_wr && hit_timer;
        req.kick  = io_rd && hit_timer;
        req.halt  = io_rd && hit_halt;
    end

endmodule

// File: rtl/wdt_sec_tick.sv
module wdt_sec_tick #(
    parameter int unsigned CLKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr || !en) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int unsigned RST_PULSE_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_pkg::wd_req_t req,
    input  logic [7:0]       wdata,
    input  logic             tick,
    output logic             restart,
    output logic             running,
    output logic             firing,
    output logic [7:0]       secs,
    output logic [7:0]       period
);
    import wdt_pkg::*;

    localparam int unsigned PW = (RST_PULSE_CLKS > 1) ? $clog2(RST_PULSE_CLKS) : 1;
    localparam logic [PW-1:0] PULSE_INIT = PW'(RST_PULSE_CLKS - 1);

    typedef struct packed {
        wd_mode_e      mode;
        logic [7:0]    period;
        logic [7:0]    secs;
        logic [PW-1:0] pulse;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     can_arm;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        can_arm = req.kick && (st_q.period != 8'd0);

        if (req.load && st_q.mode != WD_FIRE) begin
            st_d.period = wdata;
        end

        unique case (st_q.mode)
            WD_OFF: begin
                if (can_arm) begin
                    st_d.mode = WD_RUN;
                    st_d.secs = st_q.period;
                    restart   = 1'b1;
                end
            end
            WD_RUN: begin
                if (req.halt) begin
                    st_d.mode = WD_OFF;
                    st_d.secs = 8'd0;
                end else if (can_arm) begin
                    st_d.secs = st_q.period;
                    restart   = 1'b1;
                end else if (tick) begin
                    if (st_q.secs <= 8'd1) begin
                        st_d.mode  = WD_FIRE;
                        st_d.secs  = 8'd0;
                        st_d.pulse = PULSE_INIT;
                    end else begin
                        st_d.secs = st_q.secs - 8'd1;
                    end
                end
            end
            WD_FIRE: begin
                if (st_q.pulse == '0) begin
                    st_d.mode = WD_OFF;
                end else begin
                    st_d.pulse = st_q.pulse - 1'b1;
                end
            end
            default: begin
                st_d.mode = WD_OFF;
                st_d.secs = 8'd0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= WD_OFF;
            st_q.period <= 8'd0;
            st_q.secs   <= 8'd0;
            st_q.pulse  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = (st_q.mode == WD_RUN);
    assign firing  = (st_q.mode == WD_FIRE);
    assign secs    = st_q.secs;
    assign period  = st_q.period;

endmodule

// File: rtl/wdt_ioport.sv
module wdt_ioport #(
    parameter int unsigned       ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] TIMER_PORT     = 'h0543,
    parameter logic [ADDR_W-1:0] HALT_PORT_A    = 'h0143,
    parameter logic [ADDR_W-1:0] HALT_PORT_B    = 'h0943,
    parameter int unsigned       CLKS_PER_SEC   = 50_000_000,
    parameter int unsigned       RST_PULSE_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic              reset_out,
    output logic              armed,
    output logic [7:0]        secs_left
);
    wdt_pkg::wd_req_t req;
    logic             tick;
    logic             restart;
    logic             running;
    logic             firing;
    logic [7:0]       period_q;

    wdt_port_decode #(
        .ADDR_W      (ADDR_W),
        .TIMER_PORT  (TIMER_PORT),
        .HALT_PORT_A (HALT_PORT_A),
        .HALT_PORT_B (HALT_PORT_B)
    ) dec_i (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .req     (req)
    );

    wdt_sec_tick #(
        .CLKS_PER_SEC (CLKS_PER_SEC)
    ) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .clr   (restart),
        .tick  (tick)
    );

    wdt_core #(
        .RST_PULSE_CLKS (RST_PULSE_CLKS)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .wdata   (io_wdata),
        .tick    (tick),
        .restart (restart),
        .running (running),
        .firing  (firing),
        .secs    (secs_left),
        .period  (period_q)
    );

    assign reset_out = firing;
    assign armed     = running;

endmodule

// File: rtl/wdt_ioport_chk.sv
module wdt_ioport_chk #(
    parameter int unsigned       ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] TIMER_PORT     = 'h0543,
    parameter logic [ADDR_W-1:0] HALT_PORT_A    = 'h0143,
    parameter logic [ADDR_W-1:0] HALT_PORT_B    = 'h0943,
    parameter int unsigned       RST_PULSE_CLKS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              reset_out,
    input logic              armed,
    input logic [7:0]        secs_left,
    input logic [7:0]        period_q
);
    logic        kick_rd;
    logic        halt_rd;
    int unsigned pulse_len_q;

    assign kick_rd = io_rd && (io_addr == TIMER_PORT);
    assign halt_rd = io_rd && (io_addr == HALT_PORT_A || io_addr == HALT_PORT_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pulse_len_q <= 0;
        else if (reset_out) pulse_len_q <= pulse_len_q + 1;
        else                pulse_len_q <= 0;
    end

    // R3: arming read loads the stored period
    a_r3_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_rd && period_q != 8'd0 && !reset_out) |=> (armed && secs_left == $past(period_q)));

    // R4: zero period never arms
    a_r4_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_rd && period_q == 8'd0 && !armed) |=> !armed);

    // R5: halt read disarms
    a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt_rd |=> (!armed && secs_left == 8'd0));

    // R6: count moves by at most one second per cycle unless refreshed
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !kick_rd) |=> (!armed || secs_left == $past(secs_left)
                                 || secs_left == $past(secs_left) - 8'd1));

    // R8: timer is disarmed while the reset pulse is driven
    a_r8_pulse_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |-> !armed);

    // R8: pulse never exceeds its length
    a_r8_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |-> (pulse_len_q < RST_PULSE_CLKS));

    // R8: pulse ends at exactly its length
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_out) |-> (pulse_len_q == RST_PULSE_CLKS));

    // R10: reads during the pulse do not arm
    a_r10_fire_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_out && kick_rd) |=> !armed);

endmodule

bind wdt_ioport wdt_ioport_chk #(
    .ADDR_W         (ADDR_W),
    .TIMER_PORT     (TIMER_PORT),
    .HALT_PORT_A    (HALT_PORT_A),
    .HALT_PORT_B    (HALT_PORT_B),
    .RST_PULSE_CLKS (RST_PULSE_CLKS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .reset_out (reset_out),
    .armed     (armed),
    .secs_left (secs_left),
    .period_q  (period_q)
);

// File: tb/wdt_ioport_tb_top.sv
module wdt_ioport_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CPS        = 10;
    localparam int PULSE      = 4;
    localparam int NVEC       = 24;

    localparam logic [1:0] OP_NONE = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;

    // {req[46:43], op[42:41], addr[40:25], data[24:17], wait[16:9], armed[8], secs[7:0]}
    localparam logic [46:0] VEC [NVEC] = '{
        {4'd4,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b0, 8'd0},  // R4 zero period
        {4'd2,  OP_WR,   16'h0543, 8'h05, 8'd0,  1'b0, 8'd0},  // R2 write no arm
        {4'd3,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd5},  // R3 arm
        {4'd6,  OP_NONE, 16'h0000, 8'h00, 8'd9,  1'b1, 8'd4},  // R6 one second
        {4'd7,  OP_WR,   16'h0543, 8'h02, 8'd0,  1'b1, 8'd4},  // R7 write while armed
        {4'd7,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd2},  // R7 refresh reloads
        {4'd6,  OP_NONE, 16'h0000, 8'h00, 8'd14, 1'b1, 8'd1},  // R6
        {4'd5,  OP_RD,   16'h0143, 8'h00, 8'd0,  1'b0, 8'd0},  // R5 halt A
        {4'd5,  OP_NONE, 16'h0000, 8'h00, 8'd30, 1'b0, 8'd0},  // R5 stays off
        {4'd3,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd2},  // R3
        {4'd5,  OP_RD,   16'h0943, 8'h00, 8'd0,  1'b0, 8'd0},  // R5 halt B
        {4'd3,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd2},  // R3
        {4'd9,  OP_RD,   16'h0544, 8'h00, 8'd5,  1'b1, 8'd2},  // R9 other addr
        {4'd9,  OP_WR,   16'h0143, 8'h00, 8'd0,  1'b1, 8'd2},  // R9 write to halt port
        {4'd9,  OP_RD,   16'h0043, 8'h00, 8'd0,  1'b1, 8'd2},  // R9 other addr
        {4'd6,  OP_NONE, 16'h0000, 8'h00, 8'd0,  1'b1, 8'd2},  // R6 edge 9
        {4'd6,  OP_NONE, 16'h0000, 8'h00, 8'd0,  1'b1, 8'd1},  // R6 edge 10
        {4'd5,  OP_RD,   16'h0143, 8'h00, 8'd0,  1'b0, 8'd0},  // R5
        {4'd2,  OP_WR,   16'h0543, 8'h03, 8'd0,  1'b0, 8'd0},  // R2
        {4'd3,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd3},  // R3
        {4'd7,  OP_WR,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd3},  // R7 zero written while armed
        {4'd6,  OP_NONE, 16'h0000, 8'h00, 8'd8,  1'b1, 8'd2},  // R6
        {4'd4,  OP_RD,   16'h0543, 8'h00, 8'd0,  1'b1, 8'd2},  // R4 zero kick while armed
        {4'd5,  OP_RD,   16'h0143, 8'h00, 8'd0,  1'b0, 8'd0}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        reset_out;
    logic        armed;
    logic [7:0]  secs_left;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (reset_out) rst_seen++;

    wdt_ioport #(
        .CLKS_PER_SEC   (CPS),
        .RST_PULSE_CLKS (PULSE)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .reset_out (reset_out),
        .armed     (armed),
        .secs_left (secs_left)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; the access is sampled on the next rising edge
    task automatic bus_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_rd    = (op == OP_RD);
        io_wr    = (op == OP_WR);
        @(negedge clk);
        io_rd    = 1'b0;
        io_wr    = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, bench hung");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        check("R1 armed in reset", armed, 0);
        check("R1 reset_out in reset", reset_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 secs after reset", secs_left, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_op(VEC[i][42:41], VEC[i][40:25], VEC[i][24:17]);
            repeat (int'(VEC[i][16:9])) @(negedge clk);
            check($sformatf("R%0d row %0d armed", VEC[i][46:43], i), armed, int'(VEC[i][8]));
            check($sformatf("R%0d row %0d secs", VEC[i][46:43], i), secs_left, int'(VEC[i][7:0]));
        end

        // R6: refresh restarts the prescaler
        bus_op(OP_WR, 16'h0543, 8'h03);
        bus_op(OP_RD, 16'h0543, 8'h00);
        repeat (5) @(negedge clk);
        bus_op(OP_RD, 16'h0543, 8'h00);
        repeat (9) @(negedge clk);
        check("R6 full first second after refresh", secs_left, 3);
        @(negedge clk);
        check("R6 drop after one second", secs_left, 2);
        bus_op(OP_RD, 16'h0143, 8'h00);

        // R7: periodic refresh keeps reset away
        rst_seen = 0;
        bus_op(OP_RD, 16'h0543, 8'h00);
        for (int k = 0; k < 4; k++) begin
            repeat (25) @(negedge clk);
            bus_op(OP_RD, 16'h0543, 8'h00);
        end
        check("R7 no reset with refresh", rst_seen, 0);
        check("R7 still armed", armed, 1);
        bus_op(OP_RD, 16'h0943, 8'h00);

        // R8: expiry timing and pulse, R10: access during pulse
        bus_op(OP_RD, 16'h0543, 8'h00);
        repeat (29) @(negedge clk);
        check("R8 no reset before expiry", reset_out, 0);
        check("R8 last second", secs_left, 1);
        @(negedge clk);
        check("R8 reset rises", reset_out, 1);
        check("R8 disarmed in pulse", armed, 0);
        bus_op(OP_RD, 16'h0543, 8'h00);
        check("R10 read in pulse ignored", armed, 0);
        check("R8 pulse cycle 2", reset_out, 1);
        @(negedge clk);
        check("R8 pulse cycle 3", reset_out, 1);
        @(negedge clk);
        check("R8 pulse cycle 4", reset_out, 1);
        @(negedge clk);
        check("R8 pulse ended", reset_out, 0);
        check("R8 disarmed after pulse", armed, 0);
        bus_op(OP_RD, 16'h0543, 8'h00);
        check("R8 period kept", secs_left, 3);

        // R1: reset while armed clears period
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset disarms", armed, 0);
        check("R1 reset clears secs", secs_left, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_op(OP_RD, 16'h0543, 8'h00);
        check("R1 period cleared", armed, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule